// File: doc/BRIEF.md
# Interval timer host register front end

This block sits between a byte-wide host bus and three independent counting channels of an interval timer. The host sees four byte addresses. Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 is the control port. Control words set each channel's byte access pattern, counting mode and number format. Data writes are placed into a 16-bit count register for each channel. When a count is complete, a one-cycle load strobe tells the channel to take it.

For reads, the block returns either the channel's live count or a frozen snapshot. A snapshot is taken by a counter-latch command, or by a readback command that can capture the count and/or status of several channels in one write. Each channel has one flip-flop that tracks the low/high byte position for reads and another for writes. The counting itself happens in the channels. They return their live count, output level and null-count flag to this block.

A parameter selects the enhanced variant or the basic variant. Only the enhanced variant accepts readback commands and returns the control word when the control port is read.

Top module: `tmr_regfront`

## Requirements
- R1: A write to address 3 with bits 7:6 = channel 0..2 and bits 5:4 nonzero updates that channel. Its mode output takes bits 3:1 and its BCD output takes bit 0, starting the cycle after the write. The write also returns both of that channel's byte flip-flops to the low byte.
- R2: The access field is bits 5:4. Code 01 means low byte only: a data write sets count = {8'h00, byte}. Code 10 means high byte only: a data write sets count = {byte, 8'h00}. In both cases the channel's load strobe is high for exactly the cycle after the write.
- R3: Access code 11 means low byte, then high byte. The first data write fills bits 7:0 and raises no load strobe. The second fills bits 15:8 and raises the load strobe. Load and stop are never high together.
- R4: With access code 11 and mode 0, the low-byte write raises the channel's stop strobe for one cycle.
- R5: Access code 00 is a counter-latch command. It captures the live count. Data reads then return the captured value, even while the live count changes, until one byte (codes 01/10) or two bytes (code 11) have been read. Further latch commands are ignored while a capture is still unread.
- R6: A control write with bits 7:6 = 11 is a readback command on the enhanced variant only. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the selected counts and bit 4 = 0 latches their status. The basic variant ignores the command.
- R7: The status byte is {output level, null-count, last control bits 5:0}. A pending status byte is returned on the next data read, ahead of any latched count.
- R8: Unlatched reads return the live count. Code 01 returns the low byte and code 10 the high byte. Code 11 returns the low byte, then the high byte, alternately.
- R9: With code 11 and only the low byte written so far, a data read returns the bitwise inverse of count bits 7:0.
- R10: A read of address 3 returns the last channel control word on the enhanced variant, unchanged by readback commands, and 8'h00 on the basic variant.
- R11: After reset all counts, modes, strobes and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (advances byte pointers and latches) |
| addr | input | 2 | Port address: 0..2 data, 3 control |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte for the current address |
| chMode | output | 3*NUM_CH | Counting mode for each channel |
| chBcd | output | NUM_CH | Decimal count flag for each channel |
| chCount | output | 16*NUM_CH | Count register for each channel |
| chLoad | output | NUM_CH | One-cycle strobe: count is complete |
| chStop | output | NUM_CH | One-cycle strobe: halt the channel and drive its output low |
| liveCount | input | 16*NUM_CH | Current count from each channel |
| outLevel | input | NUM_CH | Output level of each channel |
| nullCount | input | NUM_CH | Null-count flag of each channel |

## Verification
The internal state that matters is a byte flip-flop that has slipped, a snapshot that did not freeze, or a status byte left pending. Each of these shows up on rdData at the very next data read of that channel, as a swapped byte, a live value in place of the frozen one, or a status byte out of order. That is why the reads are chained directly after each command. A wrong write pointer shows up on chCount and chLoad in the cycle after the second byte. A wrong decode shows up on chMode and chBcd one cycle after the control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic ctlWr;
    logic cntLatch;
    logic statLatch;
    logic dataWr;
    logic dataRd;
  } chStrb_t;

  localparam logic [1:0] ACC_LATCH = 2'd0;
  localparam logic [1:0] ACC_LO    = 2'd1;
  localparam logic [1:0] ACC_HI    = 2'd2;
  localparam logic [1:0] ACC_PAIR  = 2'd3;
  localparam logic [1:0] CTRL_ADDR = 2'd3;
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter bit ENHANCED = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [1:0]    addr,
  input  logic [7:0]    wrData,
  output chStrb_t       strb [NUM_CH],
  output logic [7:0]    ctrlByte
);
  logic isCtl, isReadback;
  logic [7:0] lastCtrl;

  assign isCtl      = wrEn && (addr == CTRL_ADDR);
  assign isReadback = (wrData[7:6] == 2'd3);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strb[i] = '0;
      if (isCtl && !isReadback && (wrData[7:6] == 2'(i))) begin
        if (wrData[5:4] == ACC_LATCH) strb[i].cntLatch = 1'b1;
        else                          strb[i].ctlWr    = 1'b1;
      end
      if (ENHANCED && isCtl && isReadback && wrData[i+1]) begin
        strb[i].cntLatch  = !wrData[5];
        strb[i].statLatch = !wrData[4];
      end
      strb[i].dataWr = wrEn && (addr == 2'(i));
      strb[i].dataRd = rdEn && (addr == 2'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastCtrl <= '0;
    else if (isCtl && !isReadback) lastCtrl <= wrData;
  end

  assign ctrlByte = ENHANCED ? lastCtrl : 8'h00;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chStrb_t          strb,
  input  logic [7:0]       wrData,
  input  logic [CNT_W-1:0] liveCnt,
  input  logic             outLvl,
  input  logic             nullCnt,
  output logic [2:0]       mode,
  output logic             bcd,
  output logic [CNT_W-1:0] cnt,
  output logic             load,
  output logic             stop,
  output logic [7:0]       rdByte
);
  localparam int HI_LSB = CNT_W - 8;

  logic [5:0]       ctrlBits;
  logic             wrHi, rdHi, statPend;
  logic [CNT_W-1:0] latchVal;
  logic [1:0]       latchLeft;
  logic [7:0]       statVal;
  logic [1:0]       acc;

  assign acc  = ctrlBits[5:4];
  assign mode = ctrlBits[3:1];
  assign bcd  = ctrlBits[0];

  always_comb begin
    rdByte = 8'h00;
    if (statPend) rdByte = statVal;
    else if (latchLeft != 2'd0)
      rdByte = (acc == ACC_HI || (acc == ACC_PAIR && rdHi)) ?
               latchVal[CNT_W-1:HI_LSB] : latchVal[7:0];
    else begin
      case (acc)
        ACC_LO:   rdByte = liveCnt[7:0];
        ACC_HI:   rdByte = liveCnt[CNT_W-1:HI_LSB];
        ACC_PAIR: rdByte = wrHi ? ~cnt[7:0] :
                           (rdHi ? liveCnt[CNT_W-1:HI_LSB] : liveCnt[7:0]);
        default:  rdByte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits  <= '0;
      wrHi      <= 1'b0;
      rdHi      <= 1'b0;
      cnt       <= '0;
      latchVal  <= '0;
      latchLeft <= '0;
      statVal   <= '0;
      statPend  <= 1'b0;
      load      <= 1'b0;
      stop      <= 1'b0;
    end else begin
      load <= 1'b0;
      stop <= 1'b0;
      if (strb.ctlWr) begin
        ctrlBits <= wrData[5:0];
        wrHi     <= 1'b0;
        rdHi     <= 1'b0;
      end
      if (strb.dataWr) begin
        case (acc)
          ACC_LO: begin cnt <= {{HI_LSB{1'b0}}, wrData}; load <= 1'b1; end
          ACC_HI: begin cnt <= {wrData, {HI_LSB{1'b0}}}; load <= 1'b1; end
          ACC_PAIR: begin
            if (!wrHi) begin
              cnt[7:0] <= wrData;
              wrHi     <= 1'b1;
              if (mode == 3'd0) stop <= 1'b1;
            end else begin
              cnt[CNT_W-1:HI_LSB] <= wrData;
              wrHi <= 1'b0;
              load <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (strb.dataRd) begin
        if (statPend) statPend <= 1'b0;
        else if (latchLeft != 2'd0) begin
          latchLeft <= latchLeft - 2'd1;
          if (acc == ACC_PAIR) rdHi <= !rdHi;
        end else if (acc == ACC_PAIR && !wrHi) rdHi <= !rdHi;
      end
      if (strb.cntLatch && latchLeft == 2'd0 && acc != ACC_LATCH) begin
        latchVal  <= liveCnt;
        latchLeft <= (acc == ACC_PAIR) ? 2'd2 : 2'd1;
      end
      if (strb.statLatch && !statPend) begin
        statVal  <= {outLvl, nullCnt, ctrlBits};
        statPend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_regfront.sv
module tmr_regfront
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int CNT_W    = 16,
  parameter bit ENHANCED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [1:0]              addr,
  input  logic [7:0]              wrData,
  output logic [7:0]              rdData,
  output logic [3*NUM_CH-1:0]     chMode,
  output logic [NUM_CH-1:0]       chBcd,
  output logic [CNT_W*NUM_CH-1:0] chCount,
  output logic [NUM_CH-1:0]       chLoad,
  output logic [NUM_CH-1:0]       chStop,
  input  logic [CNT_W*NUM_CH-1:0] liveCount,
  input  logic [NUM_CH-1:0]       outLevel,
  input  logic [NUM_CH-1:0]       nullCount
);
  chStrb_t    strb [NUM_CH];
  logic [7:0] ctrlByte;
  logic [7:0] chRd [NUM_CH];

  tmr_ctl #(.NUM_CH(NUM_CH), .ENHANCED(ENHANCED)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strb(strb), .ctrlByte(ctrlByte)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    tmr_chan #(.CNT_W(CNT_W)) uChan (
      .clk(clk), .rstN(rstN), .strb(strb[i]), .wrData(wrData),
      .liveCnt(liveCount[i*CNT_W +: CNT_W]), .outLvl(outLevel[i]),
      .nullCnt(nullCount[i]), .mode(chMode[i*3 +: 3]), .bcd(chBcd[i]),
      .cnt(chCount[i*CNT_W +: CNT_W]), .load(chLoad[i]), .stop(chStop[i]),
      .rdByte(chRd[i])
    );
  end

  always_comb begin
    rdData = 8'h00;
    if (addr == CTRL_ADDR) rdData = ctrlByte;
    else
      for (int i = 0; i < NUM_CH; i++)
        if (addr == 2'(i)) rdData = chRd[i];
  end
endmodule

// File: rtl/tmr_regfront_chk.sv
module tmr_regfront_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [1:0]              addr,
  input logic [7:0]              wrData,
  input logic [3*NUM_CH-1:0]     chMode,
  input logic [NUM_CH-1:0]       chBcd,
  input logic [NUM_CH-1:0]       chLoad,
  input logic [NUM_CH-1:0]       chStop
);
  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    // R2
    load_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      chLoad[i] |-> $past(wrEn && addr == 2'(i)));
    // R4
    stop_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      chStop[i] |-> $past(wrEn && addr == 2'(i)));
    // R3
    load_stop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(chLoad[i] && chStop[i]));
    // R1
    mode_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == 2'd3 && wrData[7:6] == 2'(i) && wrData[5:4] != 2'd0)
      |=> (chMode[i*3 +: 3] == $past(wrData[3:1]) && chBcd[i] == $past(wrData[0])));
  end
endmodule

bind tmr_regfront tmr_regfront_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .chMode(chMode), .chBcd(chBcd), .chLoad(chLoad), .chStop(chStop)
);

// File: tb/sim_tmr_regfront.sv
module sim_tmr_regfront;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [47:0] liveCount = '0;
  logic [2:0]  outLevel = '0, nullCount = '0;

  logic [7:0]  rdData, rdData1;
  logic [8:0]  chMode, chMode1;
  logic [2:0]  chBcd, chLoad, chStop, chBcd1, chLoad1, chStop1;
  logic [47:0] chCount, chCount1;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  tmr_regfront u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .chMode(chMode), .chBcd(chBcd),
    .chCount(chCount), .chLoad(chLoad), .chStop(chStop), .liveCount(liveCount),
    .outLevel(outLevel), .nullCount(nullCount));

  tmr_regfront #(.ENHANCED(1'b0)) u1 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData1), .chMode(chMode1), .chBcd(chBcd1),
    .chCount(chCount1), .chLoad(chLoad1), .chStop(chStop1), .liveCount(liveCount),
    .outLevel(outLevel), .nullCount(nullCount));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #2;
    if (rdEn && rstN) begin
      if (expQ.size() == 0) chk("unexpected read", {8'h0, rdData}, 16'hxxxx);
      else chk(tagQ.pop_front(), {8'h0, rdData}, {8'h0, expQ.pop_front()});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; expQ.push_back(exp); tagQ.push_back(tag); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a);
    @(negedge clk); addr = a; #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    peek(2'd0);
    chk("R11 count", chCount[15:0] | chCount[31:16] | chCount[47:32], 16'h0);
    chk("R11 mode/strobes", {7'h0, chMode}, 16'h0);
    chk("R11 rdData", {8'h0, rdData}, 16'h0);
    peek(2'd3);
    chk("R11 ctrl read", {8'h0, rdData}, 16'h0);

    // R1 / R2: ch0 low-only, mode 2, bcd
    wr(2'd3, 8'b00_01_010_1);
    chk("R1 mode ch0", {13'h0, chMode[2:0]}, 16'd2);
    chk("R1 bcd ch0", {15'h0, chBcd[0]}, 16'd1);
    wr(2'd0, 8'h5A);
    chk("R2 low-only count", chCount[15:0], 16'h005A);
    chk("R2 low-only load", {13'h0, chLoad}, 16'b001);
    liveCount[15:0] = 16'h1234;
    rd(2'd0, 8'h34, "R8 low-only live");

    // R2: ch1 high-only
    wr(2'd3, 8'b01_10_011_0);
    wr(2'd1, 8'hC3);
    chk("R2 high-only count", chCount[31:16], 16'hC300);
    chk("R2 high-only load", {13'h0, chLoad}, 16'b010);
    liveCount[31:16] = 16'hABCD;
    rd(2'd1, 8'hAB, "R8 high-only live");

    // R3 / R4 / R9: ch2 pair, mode 0
    wr(2'd3, 8'b10_11_000_0);
    wr(2'd2, 8'h78);
    chk("R4 stop on low byte", {13'h0, chStop}, 16'b100);
    chk("R3 no load on low byte", {13'h0, chLoad}, 16'b000);
    rd(2'd2, 8'h87, "R9 mid-write inverted low");
    wr(2'd2, 8'h56);
    chk("R3 pair count", chCount[47:32], 16'h5678);
    chk("R3 pair load", {13'h0, chLoad}, 16'b100);
    liveCount[47:32] = 16'h9ABC;
    rd(2'd2, 8'hBC, "R8 pair low");
    rd(2'd2, 8'h9A, "R8 pair high");

    // R5: counter latch on ch2
    wr(2'd3, 8'b10_00_0000);
    liveCount[47:32] = 16'h1111;
    wr(2'd3, 8'b10_00_0000);
    liveCount[47:32] = 16'h2222;
    rd(2'd2, 8'hBC, "R5 latched low");
    rd(2'd2, 8'h9A, "R5 latched high");
    rd(2'd2, 8'h22, "R5 released to live");

    // R6 / R7: readback on ch0 and ch1 (count and status)
    liveCount[15:0]  = 16'hBEEF;
    liveCount[31:16] = 16'h0F0F;
    liveCount[47:32] = 16'h2233;
    outLevel = 3'b010; nullCount = 3'b011;
    wr(2'd3, 8'hC6);
    liveCount[31:16] = 16'h7777;
    peek(2'd1);
    chk("R6 basic ignores readback", {8'h0, rdData1}, 16'h0077);
    rd(2'd1, 8'hE6, "R7 status first ch1");
    rd(2'd1, 8'h0F, "R6 frozen count ch1");
    rd(2'd0, 8'h55, "R7 status ch0");
    rd(2'd0, 8'hEF, "R6 frozen count ch0");
    rd(2'd2, 8'h22, "R6 unselected ch2 live high");

    // R1: control rewrite resets read flip-flop
    wr(2'd3, 8'b10_11_000_0);
    rd(2'd2, 8'h33, "R1 flip-flop reset to low");

    // R10 control read
    wr(2'd3, 8'hC6);
    peek(2'd3);
    chk("R10 basic ctrl read", {8'h0, rdData1}, 16'h0000);
    rd(2'd3, 8'hB0, "R10 enhanced ctrl read");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) chk("R8 pending reads", 16'(expQ.size()), 16'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule